// File: doc/BRIEF.md
# Byte Accumulator Core with Indexed Addressing

This block is a small 8-bit processor core built around a single accumulator. Alongside the accumulator it keeps two 8-bit index registers (X and Y), a 16-bit program counter and a two-flag status register (carry and zero). Instructions and data share one byte-wide memory with a 16-bit address space. The core expects a memory with asynchronous read: the byte at `mem_addr_o` has to be present on `mem_rdata_i` in the same cycle.

The instruction set is deliberately narrow:

- load, add with carry, subtract with borrow and store, all on the accumulator;
- load and increment on X;
- load on Y;
- set and clear of carry;
- a halt.

Operands come from one of three places: a constant in the instruction stream, a byte at a 16-bit absolute address, or a byte at that address plus X. The indexed form lets a short loop of add and increment walk through an array. When the halt opcode executes, the core stops and raises `done_o`. It stays halted until reset.

Top module: `acc_core`

## Requirements
- R1: While `rst_ni` is low, the outputs hold these values: acc, X, Y, carry and zero are 0, `pc_o` equals `RESET_PC` (default 0x0200), `done_o` is 0 and `mem_we_o` is 0.
- R2: Opcode byte encoding:
  - Bits [7:4] select the operation: 0x1 loads acc, 0x2 adds, 0x3 subtracts, 0x4 stores acc, 0x5 loads X and 0x7 loads Y.
  - Bits [3:0] select the mode: 0 is immediate (one operand byte follows), 1 is absolute and 2 is absolute plus X. Both address modes take two address bytes, low byte first.
  - 0x60 is increment X, 0x80 clears carry, 0x81 sets carry and 0x00 halts.
  - Every other byte, including a store with mode 0, is a one-byte no-op that changes no register.
- R3: The acc, X and Y loads copy the operand into their register, update zero and leave carry unchanged.
- R4: Add gives acc + operand + carry. Subtract gives acc + ~operand + carry, so carry=1 means no borrow. In both, carry becomes the bit-8 carry out. Example: load #7, add #10, set carry, subtract #3 leaves 14.
- R5: The zero flag is 1 exactly when the value just written by a load, add, subtract or X increment is 0.
- R6: Increment X adds 1 modulo 256. Clear carry and set carry act only on the carry flag.
- R7: The indexed effective address is the 16-bit base plus X, wrapping at 0xFFFF. For example, base 0xFFFE with X=3 reads address 0x0001.
- R8: A store drives `mem_we_o` high for exactly one cycle, with the effective address on `mem_addr_o` and acc on `mem_wdata_o`. No other instruction writes memory.
- R9: Cycle counts are 1 for implied and no-op bytes, 2 for immediate instructions and 4 for absolute or indexed instructions. The PC advances by the instruction length.
- R10: The halt sets `done_o` at the end of its one-cycle fetch. After that, PC, registers and flags hold still and memory is never written until reset.
- R11: The array-sum program (load acc #0, load X #0, three rounds of indexed add from 1000 followed by increment X, then a store to 1003) turns the bytes 30, 20 and 10 into 60 at address 1003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | 16 | Memory address: PC during fetch and operand cycles, effective address in the data cycle |
| mem_rdata_i | input | 8 | Memory read data, combinational from `mem_addr_o` |
| mem_wdata_o | output | 8 | Store data |
| mem_we_o | output | 1 | Store strobe, one cycle |
| done_o | output | 1 | Core halted |
| acc_o | output | 8 | Accumulator |
| x_o | output | 8 | X index register |
| y_o | output | 8 | Y index register |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| pc_o | output | 16 | Program counter |

## Verification
A wrong PC or a wrong state sequence shows up on `mem_addr_o` within one cycle, because the next fetch or operand byte comes from the wrong place. It also shows up as a changed count of cycles to `done_o`. A wrong index sum appears on `mem_addr_o` in the data cycle of that same instruction. A wrong carry or acc value is visible on the register outputs from the following edge, and it reaches memory at the next store. Random programs are compared register by register and byte by byte over a data window, and directed programs pin the wrap, borrow and no-op corners.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [3:0] {
    OP_NOP, OP_HLT, OP_LDA, OP_ADC, OP_SBC, OP_STA,
    OP_LDX, OP_INX, OP_LDY, OP_CLC, OP_SEC
  } op_e;

  typedef enum logic [1:0] {M_IMP, M_IMM, M_ABS, M_ABX} mode_e;

  typedef enum logic [2:0] {S_FETCH, S_IMM, S_LO, S_HI, S_MEM} state_e;

  typedef struct packed {
    op_e   op;
    mode_e mode;
  } dec_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [7:0] opc_i,
  output dec_t       dec_o
);

  logic  has_operand;
  op_e   class_op;

  always_comb begin
    has_operand = 1'b1;
    class_op    = OP_NOP;
    unique case (opc_i[7:4])
      4'h1:    class_op = OP_LDA;
      4'h2:    class_op = OP_ADC;
      4'h3:    class_op = OP_SBC;
      4'h4:    class_op = OP_STA;
      4'h5:    class_op = OP_LDX;
      4'h7:    class_op = OP_LDY;
      default: has_operand = 1'b0;
    endcase
  end

  always_comb begin
    dec_o.op   = OP_NOP;
    dec_o.mode = M_IMP;
    if (has_operand) begin
      unique case (opc_i[3:0])
        4'h0: if (class_op != OP_STA) begin
          dec_o.op   = class_op;
          dec_o.mode = M_IMM;
        end
        4'h1: begin
          dec_o.op   = class_op;
          dec_o.mode = M_ABS;
        end
        4'h2: begin
          dec_o.op   = class_op;
          dec_o.mode = M_ABX;
        end
        default: ;
      endcase
    end else begin
      unique case (opc_i)
        8'h00:   dec_o.op = OP_HLT;
        8'h60:   dec_o.op = OP_INX;
        8'h80:   dec_o.op = OP_CLC;
        8'h81:   dec_o.op = OP_SEC;
        default: dec_o.op = OP_NOP;
      endcase
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);

  // subtract = add of the complement; carry in acts as "no borrow"
  logic [DW-1:0] b_eff;
  assign b_eff = sub_i ? ~b_i : b_i;
  assign {cout_o, res_o} = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin_i};

endmodule

// File: rtl/acc_agen.sv
module acc_agen #(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] idx_i,
  input  logic          use_idx_i,
  output logic [AW-1:0] ea_o
);

  logic [AW-1:0] base;
  logic [AW-1:0] offs;

  assign base = {hi_i, lo_i};
  assign offs = use_idx_i ? AW'(idx_i) : '0;
  assign ea_o = base + offs;  // wraps at the top of the address space

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int            DW       = 8,
  parameter int            AW       = 2 * DW,
  parameter logic [AW-1:0] RESET_PC = AW'('h200)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          done_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o,
  output logic          carry_o,
  output logic          zero_o,
  output logic [AW-1:0] pc_o
);

  localparam int OPW = 8;

  state_e         state_q, state_d;
  logic [AW-1:0]  pc_q;
  logic [DW-1:0]  acc_q, x_q, y_q, lo_q, hi_q;
  logic [OPW-1:0] ir_q;
  logic           carry_q, zero_q, done_q;

  logic [OPW-1:0] dec_in;
  dec_t           dec;
  logic           exec_en;
  logic [DW-1:0]  alu_res;
  logic           alu_cout;
  logic [DW-1:0]  x_inc;
  logic [AW-1:0]  ea;

  // opcode comes straight from memory in fetch, from ir_q afterwards
  assign dec_in = (state_q == S_FETCH) ? mem_rdata_i[OPW-1:0] : ir_q;

  acc_decode u_dec (
    .opc_i(dec_in),
    .dec_o(dec)
  );

  acc_alu #(.DW(DW)) u_alu (
    .a_i   (acc_q),
    .b_i   (mem_rdata_i),
    .cin_i (carry_q),
    .sub_i (dec.op == OP_SBC),
    .res_o (alu_res),
    .cout_o(alu_cout)
  );

  acc_agen #(.DW(DW), .AW(AW)) u_agen (
    .lo_i     (lo_q),
    .hi_i     (hi_q),
    .idx_i    (x_q),
    .use_idx_i(dec.mode == M_ABX),
    .ea_o     (ea)
  );

  assign x_inc   = x_q + DW'(1);
  assign exec_en = (state_q == S_FETCH && dec.mode == M_IMP && !done_q)
                 || state_q == S_IMM || state_q == S_MEM;

  assign mem_addr_o  = (state_q == S_MEM) ? ea : pc_q;
  assign mem_we_o    = (state_q == S_MEM) && (dec.op == OP_STA);
  assign mem_wdata_o = acc_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_FETCH: begin
        unique case (dec.mode)
          M_IMM:        state_d = S_IMM;
          M_ABS, M_ABX: state_d = S_LO;
          default:      state_d = S_FETCH;
        endcase
      end
      S_IMM:   state_d = S_FETCH;
      S_LO:    state_d = S_HI;
      S_HI:    state_d = S_MEM;
      S_MEM:   state_d = S_FETCH;
      default: state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      pc_q    <= RESET_PC;
      ir_q    <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      acc_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (!done_q) begin
      state_q <= state_d;
      unique case (state_q)
        S_FETCH: begin
          ir_q <= mem_rdata_i[OPW-1:0];
          if (dec.op == OP_HLT) done_q <= 1'b1;
          else                  pc_q   <= pc_q + AW'(1);
        end
        S_IMM: pc_q <= pc_q + AW'(1);
        S_LO: begin
          lo_q <= mem_rdata_i;
          pc_q <= pc_q + AW'(1);
        end
        S_HI: begin
          hi_q <= mem_rdata_i;
          pc_q <= pc_q + AW'(1);
        end
        default: ;
      endcase
      if (exec_en) begin
        unique case (dec.op)
          OP_LDA: begin
            acc_q  <= mem_rdata_i;
            zero_q <= (mem_rdata_i == '0);
          end
          OP_ADC, OP_SBC: begin
            acc_q   <= alu_res;
            carry_q <= alu_cout;
            zero_q  <= (alu_res == '0);
          end
          OP_LDX: begin
            x_q    <= mem_rdata_i;
            zero_q <= (mem_rdata_i == '0);
          end
          OP_LDY: begin
            y_q    <= mem_rdata_i;
            zero_q <= (mem_rdata_i == '0);
          end
          OP_INX: begin
            x_q    <= x_inc;
            zero_q <= (x_inc == '0);
          end
          OP_CLC:  carry_q <= 1'b0;
          OP_SEC:  carry_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign done_o  = done_q;
  assign acc_o   = acc_q;
  assign x_o     = x_q;
  assign y_o     = y_q;
  assign carry_o = carry_q;
  assign zero_o  = zero_q;
  assign pc_o    = pc_q;

  // R10: once halted nothing moves and nothing is written
  assert_halt_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> (done_q && $stable(pc_q) && $stable(acc_q) && $stable(x_q) && !mem_we_o));

  // R9: every non-halt fetch consumes exactly one byte
  assert_pc_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FETCH && !done_q && dec.op != OP_HLT) |=> (pc_q == $past(pc_q) + AW'(1)));

  // R7: the indexed data access presents base + X, wrapped
  assert_index_ea_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_MEM && dec.mode == M_ABX) |-> (mem_addr_o == ({hi_q, lo_q} + AW'(x_q))));

  // R5: zero follows the value that landed in acc
  assert_zero_tracks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en && (dec.op == OP_LDA || dec.op == OP_ADC || dec.op == OP_SBC))
      |=> (zero_q == (acc_q == '0)));

  // R3: loads leave carry alone
  assert_load_keeps_carry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en && (dec.op == OP_LDA || dec.op == OP_LDX || dec.op == OP_LDY))
      |=> (carry_q == $past(carry_q)));

  // R8: writes only in the data cycle of a store
  assert_store_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($past(state_q) == S_HI && !done_q));

endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata;
  logic        mem_we, done;
  logic [7:0]  acc, xr, yr;
  logic        carry, zero;
  logic [15:0] pc;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] mem     [0:4095];
  logic [7:0] ref_mem [0:4095];

  always #4 clk = ~clk;

  acc_core dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .done_o(done),
    .acc_o(acc), .x_o(xr), .y_o(yr), .carry_o(carry), .zero_o(zero), .pc_o(pc)
  );

  assign mem_rdata = mem[mem_addr[11:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // program construction
  logic [15:0] ptr;
  task automatic put(input logic [15:0] a, input logic [7:0] b);
    mem[a[11:0]] = b;
    ref_mem[a[11:0]] = b;
  endtask
  task automatic emit(input logic [7:0] b);
    put(ptr, b);
    ptr = ptr + 16'd1;
  endtask
  task automatic emit_abs(input logic [7:0] op, input logic [15:0] a);
    emit(op); emit(a[7:0]); emit(a[15:8]);
  endtask

  task automatic begin_prog();
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'h00;
      ref_mem[i] = 8'h00;
    end
    ptr = 16'h0200;
  endtask

  task automatic run_dut(output int cyc);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // reference interpreter built from the requirement text
  logic [7:0]  m_acc, m_x, m_y;
  logic        m_c, m_z;
  logic [15:0] m_pc;
  int          m_cyc;

  task automatic run_model();
    logic [7:0]  op, v;
    logic [15:0] ea;
    logic [8:0]  s;
    m_acc = 0; m_x = 0; m_y = 0; m_c = 0; m_z = 0; m_pc = 16'h0200; m_cyc = 0;
    for (int step = 0; step < 500; step++) begin
      op = ref_mem[m_pc[11:0]];
      if (op == 8'h00) begin
        m_cyc += 1;
        break;
      end
      if ((op[7:4] inside {4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h7}) && op[3:0] <= 4'h2
          && !(op[7:4] == 4'h4 && op[3:0] == 4'h0)) begin
        ea = 16'h0;
        if (op[3:0] == 4'h0) begin
          v = ref_mem[m_pc[11:0] + 12'd1];
          m_pc += 16'd2;
          m_cyc += 2;
        end else begin
          ea = {ref_mem[m_pc[11:0] + 12'd2], ref_mem[m_pc[11:0] + 12'd1]};
          if (op[3:0] == 4'h2) ea = ea + {8'h00, m_x};
          v = ref_mem[ea[11:0]];
          m_pc += 16'd3;
          m_cyc += 4;
        end
        case (op[7:4])
          4'h1: begin m_acc = v; m_z = (v == 0); end
          4'h2: begin s = {1'b0, m_acc} + {1'b0, v} + {8'h00, m_c};
                      m_acc = s[7:0]; m_c = s[8]; m_z = (s[7:0] == 0); end
          4'h3: begin s = {1'b0, m_acc} + {1'b0, ~v} + {8'h00, m_c};
                      m_acc = s[7:0]; m_c = s[8]; m_z = (s[7:0] == 0); end
          4'h4: ref_mem[ea[11:0]] = m_acc;
          4'h5: begin m_x = v; m_z = (v == 0); end
          default: begin m_y = v; m_z = (v == 0); end
        endcase
      end else begin
        if (op == 8'h60) begin m_x = m_x + 8'd1; m_z = (m_x == 0); end
        else if (op == 8'h80) m_c = 1'b0;
        else if (op == 8'h81) m_c = 1'b1;
        m_pc += 16'd1;
        m_cyc += 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: act=hung exp=halted");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] pc_hold;
    logic [15:0] b;
    int k, nbad_mem;
    void'($urandom(32'h5eed));

    // R1 reset state
    begin_prog();
    @(negedge clk);
    chk("R1", "acc", acc, 0);       chk("R1", "x", xr, 0);
    chk("R1", "y", yr, 0);          chk("R1", "carry", carry, 0);
    chk("R1", "zero", zero, 0);     chk("R1", "pc", pc, 16'h0200);
    chk("R1", "done", done, 0);     chk("R1", "we", mem_we, 0);

    // R4/R9: 7, +10, set carry, -3 -> 14 ; bytes after halt must never run (R10)
    begin_prog();
    emit(8'h10); emit(8'd7); emit(8'h20); emit(8'd10); emit(8'h81);
    emit(8'h30); emit(8'd3); emit(8'h00); emit_abs(8'h41, 16'h0903);
    run_dut(cyc);
    chk("R4", "acc 7+10-3", acc, 8'd14);
    chk("R4", "carry no borrow", carry, 1);
    chk("R9", "cycles", cyc, 8);
    chk("R9", "pc at halt", pc, 16'h0207);
    pc_hold = pc;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_we || pc != pc_hold || !done) begin
        chk("R10", "halt hold", {mem_we, done, pc}, {1'b0, 1'b1, pc_hold});
        break;
      end
    end
    chk("R10", "no store after halt", mem[12'h903], 0);
    chk("R10", "acc held", acc, 8'd14);

    // R11/R7/R6/R8 array sum
    begin_prog();
    put(16'd1000, 8'd30); put(16'd1001, 8'd20); put(16'd1002, 8'd10);
    emit(8'h10); emit(8'h00); emit(8'h50); emit(8'h00);
    for (int i = 0; i < 3; i++) begin
      emit_abs(8'h22, 16'd1000);
      if (i < 2) emit(8'h60);
    end
    emit_abs(8'h41, 16'd1003); emit(8'h00);
    run_dut(cyc);
    chk("R11", "sum in 1003", mem[12'd1003], 8'd60);
    chk("R11", "acc", acc, 8'd60);
    chk("R6", "x stepped", xr, 8'd2);
    chk("R8", "source untouched", mem[12'd1002], 8'd10);
    chk("R9", "array cycles", cyc, 23);

    // R7 index wrap: 0xFFFE + 3 -> 0x0001
    begin_prog();
    put(16'h0001, 8'h5A); put(16'h0FFE, 8'h11); put(16'h0FFF, 8'h22);
    emit(8'h50); emit(8'd3); emit_abs(8'h12, 16'hFFFE); emit(8'h00);
    run_dut(cyc);
    chk("R7", "wrapped indexed load", acc, 8'h5A);

    // R4 carry out then carry in
    begin_prog();
    emit(8'h10); emit(8'hF0); emit(8'h20); emit(8'h20);
    emit_abs(8'h41, 16'h0900); emit(8'h20); emit(8'h00); emit(8'h00);
    run_dut(cyc);
    chk("R4", "F0+20", mem[12'h900], 8'h10);
    chk("R4", "carry in used", acc, 8'h11);
    chk("R4", "carry cleared", carry, 0);

    // R4/R5 borrow cases
    begin_prog();
    emit(8'h80); emit(8'h10); emit(8'd5); emit(8'h30); emit(8'd5);
    emit_abs(8'h41, 16'h0901);
    emit(8'h81); emit(8'h10); emit(8'd5); emit(8'h30); emit(8'd5); emit(8'h00);
    run_dut(cyc);
    chk("R4", "5-5 with borrow", mem[12'h901], 8'hFF);
    chk("R5", "5-5 zero", zero, 1);
    chk("R4", "5-5 carry", carry, 1);

    // R3/R6/R5: Y load, load keeps carry, X wraps to zero
    begin_prog();
    put(16'h0902, 8'h80);
    emit_abs(8'h71, 16'h0902); emit(8'h81); emit(8'h10); emit(8'h00);
    emit(8'h50); emit(8'hFF); emit(8'h60); emit(8'h00);
    run_dut(cyc);
    chk("R3", "y abs", yr, 8'h80);
    chk("R3", "carry kept over load", carry, 1);
    chk("R6", "x wrap", xr, 8'h00);
    chk("R5", "zero after inx wrap", zero, 1);
    chk("R9", "mixed cycles", cyc, 11);

    // R2 undefined bytes are one-byte no-ops
    begin_prog();
    emit(8'h10); emit(8'h33); emit(8'h13); emit(8'h40); emit(8'h9A); emit(8'h00);
    run_dut(cyc);
    chk("R2", "acc after no-ops", acc, 8'h33);
    chk("R2", "pc after no-ops", pc, 16'h0205);
    chk("R2", "no-op cycles", cyc, 6);

    // random programs against the interpreter (R2..R9)
    for (int p = 0; p < 60; p++) begin
      begin_prog();
      for (int a = 16'h0800; a < 16'h0A00; a++) put(a[15:0], 8'($urandom));
      for (int n = 0; n < 12; n++) begin
        k = $urandom % 10;
        b = 16'h0800 + 16'($urandom % 256);
        case (k)
          0: begin emit(8'h10); emit(8'($urandom)); end
          1: emit_abs(($urandom % 2) ? 8'h12 : 8'h11, b);
          2: begin emit(8'h20); emit(8'($urandom)); end
          3: emit_abs(($urandom % 2) ? 8'h22 : 8'h21, b);
          4: begin emit(8'h30); emit(8'($urandom)); end
          5: emit_abs(($urandom % 2) ? 8'h32 : 8'h31, b);
          6: emit_abs(($urandom % 2) ? 8'h42 : 8'h41, b);
          7: begin emit(8'h50); emit(8'($urandom)); end
          8: emit(8'h60);
          default: begin
            case ($urandom % 4)
              0: emit(8'h80);
              1: emit(8'h81);
              2: begin emit(8'h70); emit(8'($urandom)); end
              default: emit(8'h13);
            endcase
          end
        endcase
      end
      emit(8'h00);
      run_model();
      run_dut(cyc);
      chk("R4", "rand acc", acc, m_acc);
      chk("R6", "rand x", xr, m_x);
      chk("R3", "rand y", yr, m_y);
      chk("R4", "rand carry", carry, m_c);
      chk("R5", "rand zero", zero, m_z);
      chk("R9", "rand pc", pc, m_pc);
      chk("R9", "rand cycles", cyc, m_cyc);
      nbad_mem = 0;
      for (int a = 12'h800; a < 12'hA00; a++)
        if (mem[a] !== ref_mem[a]) nbad_mem++;
      chk("R8", "rand data window mismatches", nbad_mem, 0);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule